// File: doc/BRIEF.md
# Single-Step Clock-Enable Generator

This block lets a processor system either run at full speed or advance one clock cycle at a time, while the system clock itself keeps running without a break. It produces a clock-enable, `cpuEnable`, for the CPU and bus logic. That logic stays on the ungated clock and advances only in cycles where the enable is high. Peripherals that need real time, such as a serial port or a timer, ignore the enable and keep working.

Two asynchronous inputs drive the block: a raw push-button and a run/step switch. Each input first passes through a flip-flop synchronizer. The button is then debounced: a new level is accepted only after it has held for a parameterised number of clocks, 20 ms at 2 MHz by default. An edge detector then turns each accepted press into a single-cycle strobe. In run mode the enable stays high. In step mode the enable is high for exactly one clock per accepted press. A mode change is held back for any cycle in which a step pulse is being issued.

Top module: `step_enable_gen`

## Requirements
- R1: While `rstN` is low, `cpuEnable` is 0 and the block is in step mode. After reset is released with `runSwitch` already at 1, `cpuEnable` stays 0 on the first two rising edges and becomes 1 on the third.
- R2: With `runSwitch` = 1 (run mode), `cpuEnable` is 1 in every cycle, and activity on `buttonRaw` has no effect on it.
- R3: In step mode, a clean press (`buttonRaw` going from 0 to 1) sets `cpuEnable` high for exactly one clock period, starting at the (DEBOUNCE_CYCLES+3)-th rising edge after the input change.
- R4: A press held for any length of time gives only one pulse. Releasing the button gives no pulse.
- R5: The debouncer accepts a new button level only after the synchronized input has differed from the accepted level for DEBOUNCE_CYCLES consecutive clocks. A press shorter than that gives no pulse. DEBOUNCE_CYCLES defaults to CLK_HZ/1000 × DEBOUNCE_MS.
- R6: A press whose edges bounce, with every bounce segment shorter than DEBOUNCE_CYCLES, gives exactly one pulse of one clock period.
- R7: If the synchronized switch requests run mode during a cycle in which a step pulse is high, the mode change is deferred by one clock. The pulse ends, `cpuEnable` is 0 for one cycle, and then it stays 1.
- R8: Changing from run mode to step mode takes `cpuEnable` to 0 on the third rising edge after the switch changes, with no stray pulse afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| buttonRaw | input | 1 | Raw, bouncing step push-button, 1 = pressed |
| runSwitch | input | 1 | Raw mode switch, 1 = run, 0 = step |
| cpuEnable | output | 1 | Clock-enable for the CPU and bus logic |

## Verification
Several properties are checked on every cycle:
- a step pulse in step mode never lasts longer than one cycle;
- the mode register never changes just after a step pulse;
- the accepted button level moves only when the stability counter has reached its limit;
- the press strobe is never high on two cycles in a row;
- the enable is low whenever reset is asserted.

Some behaviour only the directed scenarios can show, because each depends on a particular input waveform:
- the exact pulse latency;
- the rejection of glitches and bounce;
- a single pulse for a long press;
- the one-cycle gap that the deferred mode change leaves;
- the latency of the switch in both directions.

// File: rtl/stepgen_pkg.sv
package stepgen_pkg;

  // Events the datapath hands to the mode/enable control each cycle
  typedef struct packed {
    logic pressEdge;  // one-cycle strobe on an accepted press
    logic runSel;     // synchronized mode switch, 1 = run
  } dpEvents_t;

  function automatic int cntWidth(input int limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/step_sync.sv
module step_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stageQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= '0;
        else       stageQ <= dIn;
      end
      assign dOut = stageQ;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stageQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ <= '0;
        else       stageQ <= {stageQ[STAGES-2:0], dIn};
      end
      assign dOut = stageQ[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/step_datapath.sv
module step_datapath
  import stepgen_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 40000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      buttonRaw,
  input  logic      runSwitchRaw,
  output dpEvents_t events
);

  localparam int               CNT_W    = cntWidth(DEBOUNCE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

  logic [1:0]       syncQ;
  logic             btnSync;
  logic             runSync;
  logic [CNT_W-1:0] stableCnt;
  logic             btnStable;
  logic             btnStablePrev;

  step_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  ({runSwitchRaw, buttonRaw}),
    .dOut (syncQ)
  );

  assign btnSync = syncQ[0];
  assign runSync = syncQ[1];

  // Debounce: a new level must persist for DEBOUNCE_CYCLES clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stableCnt     <= '0;
      btnStable     <= 1'b0;
      btnStablePrev <= 1'b0;
    end else begin
      btnStablePrev <= btnStable;
      if (btnSync != btnStable) begin
        if (stableCnt == CNT_LAST) begin
          btnStable <= btnSync;
          stableCnt <= '0;
        end else begin
          stableCnt <= stableCnt + 1'b1;
        end
      end else begin
        stableCnt <= '0;
      end
    end
  end

  assign events.pressEdge = btnStable & ~btnStablePrev;
  assign events.runSel    = runSync;

  // R5: accepted level moves only once the stability window is full
  a_r5_accept_after_window: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(btnStable) |-> ($past(stableCnt) == CNT_LAST));

  // R4: the press strobe never lasts two cycles
  a_r4_edge_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    events.pressEdge |=> !events.pressEdge);

endmodule

// File: rtl/step_control.sv
module step_control
  import stepgen_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpEvents_t events,
  output logic      cpuEnable
);

  logic modeRun;     // 1 = run, 0 = step
  logic enReg;
  logic stepActive;  // a step pulse is on the output this cycle
  logic modeNext;
  logic enNext;

  always_comb begin
    stepActive = ~modeRun & enReg;
    modeNext   = stepActive ? modeRun : events.runSel;
    enNext     = modeNext | events.pressEdge;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeRun <= 1'b0;
      enReg   <= 1'b0;
    end else begin
      modeRun <= modeNext;
      enReg   <= enNext;
    end
  end

  assign cpuEnable = enReg;

  // R1: enable is low whenever reset is held
  a_r1_reset_low: assert property (@(posedge clk) !rstN |-> !enReg);

  // R3: a step pulse lasts one clock only
  a_r3_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (!modeRun && enReg) |=> !enReg);

  // R7: no mode change at the edge that ends a step pulse
  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!modeRun && enReg) |=> !modeRun);

endmodule

// File: rtl/step_enable_gen.sv
module step_enable_gen
  import stepgen_pkg::*;
#(
  parameter int CLK_HZ          = 2_000_000,
  parameter int DEBOUNCE_MS     = 20,
  parameter int DEBOUNCE_CYCLES = (CLK_HZ / 1000) * DEBOUNCE_MS,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic buttonRaw,
  input  logic runSwitch,
  output logic cpuEnable
);

  dpEvents_t events;

  step_datapath #(
    .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES),
    .SYNC_STAGES     (SYNC_STAGES)
  ) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .buttonRaw    (buttonRaw),
    .runSwitchRaw (runSwitch),
    .events       (events)
  );

  step_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .events    (events),
    .cpuEnable (cpuEnable)
  );

endmodule

// File: tb/step_enable_gen_tb.sv
module step_enable_gen_tb;

  localparam int CLK_PERIOD = 500;
  localparam int DB         = 8;

  logic clk = 1'b0;
  logic rstN;
  logic buttonRaw;
  logic runSwitch;
  logic cpuEnable;

  int checks = 0;
  int fails  = 0;
  int highCnt = 0;
  int lowCnt  = 0;
  int riseCnt = 0;
  logic prevEn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_enable_gen #(.DEBOUNCE_CYCLES(DB)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .buttonRaw (buttonRaw),
    .runSwitch (runSwitch),
    .cpuEnable (cpuEnable)
  );

  // Output monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN) begin
      if (cpuEnable) highCnt++; else lowCnt++;
      if (cpuEnable && !prevEn) riseCnt++;
      prevEn = cpuEnable;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // R1: reset state and switch latency out of reset
  task automatic t_reset();
    rstN = 1'b0; buttonRaw = 1'b0; runSwitch = 1'b1;
    cycles(4);
    check(cpuEnable == 1'b0, "R1 enable low in reset", cpuEnable, 0);
    rstN = 1'b1;
    cycles(1);
    check(cpuEnable == 1'b0, "R1 low after edge 1", cpuEnable, 0);
    cycles(1);
    check(cpuEnable == 1'b0, "R1 low after edge 2", cpuEnable, 0);
    cycles(1);
    check(cpuEnable == 1'b1, "R1 high after edge 3", cpuEnable, 1);
    runSwitch = 1'b0;
    cycles(6);
    check(cpuEnable == 1'b0, "R1 back to step", cpuEnable, 0);
  endtask

  // R3: clean press, exact latency and width
  task automatic t_step_clean();
    int highAt = -1;
    int highs  = 0;
    buttonRaw = 1'b1;
    for (int k = 1; k <= DB + 8; k++) begin
      cycles(1);
      if (cpuEnable) begin highs++; if (highAt < 0) highAt = k; end
    end
    check(highAt == DB + 3, "R3 pulse position", highAt, DB + 3);
    check(highs == 1, "R3 pulse width", highs, 1);
    buttonRaw = 1'b0;
    cycles(DB + 6);
  endtask

  // R4: long press then release
  task automatic t_long_press();
    int baseRise, baseHigh;
    @(posedge clk); baseRise = riseCnt; baseHigh = highCnt;
    @(negedge clk); buttonRaw = 1'b1;
    cycles(20 * DB);
    check(riseCnt - baseRise == 1, "R4 one pulse long press", riseCnt - baseRise, 1);
    check(highCnt - baseHigh == 1, "R4 one high cycle", highCnt - baseHigh, 1);
    @(posedge clk); baseRise = riseCnt;
    @(negedge clk); buttonRaw = 1'b0;
    cycles(3 * DB);
    check(riseCnt - baseRise == 0, "R4 no pulse on release", riseCnt - baseRise, 0);
  endtask

  // R5: press one cycle too short
  task automatic t_glitch();
    int baseRise;
    @(posedge clk); baseRise = riseCnt;
    @(negedge clk); buttonRaw = 1'b1;
    cycles(DB - 1);
    buttonRaw = 1'b0;
    cycles(3 * DB);
    check(riseCnt - baseRise == 0, "R5 short press rejected", riseCnt - baseRise, 0);
  endtask

  // R6: bouncing press and release
  task automatic t_bounce();
    int baseRise, baseHigh;
    @(posedge clk); baseRise = riseCnt; baseHigh = highCnt;
    @(negedge clk);
    buttonRaw = 1'b1; cycles(2);
    buttonRaw = 1'b0; cycles(1);
    buttonRaw = 1'b1; cycles(3);
    buttonRaw = 1'b0; cycles(2);
    buttonRaw = 1'b1; cycles(1);
    buttonRaw = 1'b0; cycles(4);
    buttonRaw = 1'b1; cycles(4 * DB);
    buttonRaw = 1'b0; cycles(3);
    buttonRaw = 1'b1; cycles(2);
    buttonRaw = 1'b0; cycles(1);
    buttonRaw = 1'b1; cycles(5);
    buttonRaw = 1'b0; cycles(4 * DB);
    check(riseCnt - baseRise == 1, "R6 one pulse per bounced press", riseCnt - baseRise, 1);
    check(highCnt - baseHigh == 1, "R6 pulse one cycle", highCnt - baseHigh, 1);
  endtask

  // R2 and R8: run mode, then back to step
  task automatic t_run_and_back();
    int baseLow, baseRise;
    runSwitch = 1'b1;
    cycles(5);
    @(posedge clk); baseLow = lowCnt;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      buttonRaw = ~buttonRaw; cycles(DB + 3);
    end
    buttonRaw = 1'b0;
    cycles(DB + 6);
    check(lowCnt - baseLow == 0, "R2 enable held in run", lowCnt - baseLow, 0);
    check(cpuEnable == 1'b1, "R2 enable high", cpuEnable, 1);
    runSwitch = 1'b0;
    cycles(1);
    check(cpuEnable == 1'b1, "R8 still high edge 1", cpuEnable, 1);
    cycles(1);
    check(cpuEnable == 1'b1, "R8 still high edge 2", cpuEnable, 1);
    cycles(1);
    check(cpuEnable == 1'b0, "R8 low on edge 3", cpuEnable, 0);
    @(posedge clk); baseRise = riseCnt;
    cycles(3 * DB);
    check(riseCnt - baseRise == 0, "R8 no stray pulse", riseCnt - baseRise, 0);
  endtask

  // R7: run requested during a step pulse
  task automatic t_mode_during_pulse();
    buttonRaw = 1'b1;
    cycles(DB + 1);
    runSwitch = 1'b1;
    cycles(1);
    check(cpuEnable == 1'b0, "R7 before pulse", cpuEnable, 0);
    cycles(1);
    check(cpuEnable == 1'b1, "R7 pulse", cpuEnable, 1);
    cycles(1);
    check(cpuEnable == 1'b0, "R7 gap after pulse", cpuEnable, 0);
    cycles(1);
    check(cpuEnable == 1'b1, "R7 run takes over", cpuEnable, 1);
    cycles(4);
    check(cpuEnable == 1'b1, "R7 run held", cpuEnable, 1);
    buttonRaw = 1'b0;
    runSwitch = 1'b0;
    cycles(DB + 6);
  endtask

  initial begin
    t_reset();
    t_step_clean();
    t_long_press();
    t_glitch();
    t_bounce();
    t_run_and_back();
    t_mode_during_pulse();
    t_step_clean();
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

endmodule